// File: doc/BRIEF.md
# Big-Endian Byte Lane Steering Unit

This unit sits between a 32-bit core and a data memory that is one word wide and addressed by byte. It moves bytes between the memory word and the core's registers, and it flags accesses whose address is not aligned to their size. Lanes are numbered big-endian: byte offset 0 is the most significant byte of the word, bits 31:24.

On the load side, the core raises `ld_req` for one cycle. In that cycle it presents the low address bits, the access size and a zero-extend flag. The unit registers these attributes. The memory word arrives in a later cycle. From that word and the registered attributes, the unit computes combinationally a right-justified result that is sign-extended or zero-extended to 32 bits.

On the store side, everything is combinational. The unit takes the register value, the low address bits and the size. It copies the low byte or halfword of the register onto every lane of the write word and raises only the byte enables of the addressed lane. A misaligned store raises the alignment flag and clears every enable.

Top module: `be_lane_unit`

## Requirements
- R1: After reset, the held load attributes are offset 0, word size and sign-extending. So `ld_misalign` is 0 and `ld_data` equals `mem_rdata`.
- R2: A byte load at offset k selects memory bits [31-8k : 24-8k]. Offset 0 is the most significant byte.
- R3: A sign-extending byte or halfword load (`ld_zext`=0) copies the top bit of the selected data into all upper bits of `ld_data`. For example, byte 0xFE gives 0xFFFFFFFE.
- R4: A zero-extending byte or halfword load (`ld_zext`=1) fills all upper bits of `ld_data` with 0.
- R5: A halfword load at offset 0 selects bits 31:16. At offset 2 it selects bits 15:0.
- R6: Offset, size and extend flag are captured on a clock edge where `ld_req`=1 and are held while `ld_req`=0. `ld_data` follows `mem_rdata` combinationally under the held attributes.
- R7: The held load is misaligned when it is a halfword with offset bit 0 set, or a word with a nonzero offset. In that case `ld_misalign`=1 and `ld_data`=0.
- R8: A byte store copies `st_src[7:0]` into all four lanes of `mem_wdata`. It raises exactly one enable, `mem_be[3-offset]`. Bit i of `mem_be` enables `mem_wdata[8i+7:8i]`, so offset 2 gives `mem_be`=0010.
- R9: A halfword store copies `st_src[15:0]` into both halves of `mem_wdata`. It raises `mem_be`=1100 at offset 0 and 0011 at offset 2.
- R10: An aligned word store passes `st_src` to `mem_wdata` unchanged and raises `mem_be`=1111.
- R11: A misaligned store (same rule as R7) with `st_valid`=1 raises `st_misalign` and drives `mem_be`=0000.
- R12: With `st_valid`=0, `mem_be` is 0000 and `st_misalign` is 0.
- R13: Size code 2'b11 behaves as a word access on both paths. Size codes are 00 byte, 01 halfword, 10 word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_req | input | 1 | Capture load attributes this cycle |
| ld_ofs | input | 2 | Load byte offset within the word |
| ld_size | input | 2 | Load size code |
| ld_zext | input | 1 | 1 = zero-extend, 0 = sign-extend |
| mem_rdata | input | 32 | Word read from memory |
| ld_data | output | 32 | Aligned, extended load result |
| ld_misalign | output | 1 | Held load is misaligned |
| st_valid | input | 1 | Store access present |
| st_ofs | input | 2 | Store byte offset within the word |
| st_size | input | 2 | Store size code |
| st_src | input | 32 | Register value to store |
| mem_wdata | output | 32 | Lane-replicated write word |
| mem_be | output | 4 | Byte write enables, bit i for bits 8i+7:8i |
| st_misalign | output | 1 | Store is misaligned |

## Verification
The data phase of a load and a new store can occur in the same cycle. The bench provokes this in every random iteration. While `ld_data` is being produced from attributes captured earlier, it applies a fresh store and new junk load-address values with `ld_req` low. It then judges both paths in that cycle against bench reference functions: the load result must reflect only the held attributes, and the store word and enables must reflect only the current store inputs.

// File: rtl/lane_pkg.sv
package lane_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_WIDE = 2'b11
   } acc_size_e;
endpackage

// File: rtl/lane_align_check.sv
module lane_align_check
   import lane_pkg::*;
#(
   parameter int OFS_W = 2
)(
   input  acc_size_e        size_i,
   input  logic [OFS_W-1:0] ofs_i,
   output logic             misalign_o
);
   always_comb begin
      case (size_i)
         SZ_BYTE: misalign_o = 1'b0;
         SZ_HALF: misalign_o = ofs_i[0];
         default: misalign_o = |ofs_i;
      endcase
   end
endmodule

// File: rtl/lane_load_extract.sv
module lane_load_extract
   import lane_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int BYTE_W    = 8,
   parameter int NUM_LANES = DATA_W / BYTE_W,
   parameter int OFS_W     = $clog2(NUM_LANES)
)(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [DATA_W-1:0] rdata_i,
   input  logic [OFS_W-1:0]  ofs_i,
   input  acc_size_e         size_i,
   input  logic              zext_i,
   input  logic              misalign_i,
   output logic [DATA_W-1:0] data_o
);
   localparam int HALF_W  = 2 * BYTE_W;
   localparam int NUM_HLF = NUM_LANES / 2;
   localparam int EXT_B   = DATA_W - BYTE_W;
   localparam int EXT_H   = DATA_W - HALF_W;

   logic [BYTE_W-1:0] lane_b [NUM_LANES];
   logic [HALF_W-1:0] lane_h [NUM_HLF];
   logic [BYTE_W-1:0] sel_b;
   logic [HALF_W-1:0] sel_h;

   for (genvar i = 0; i < NUM_LANES; i++) begin : g_blane
      assign lane_b[i] = rdata_i[DATA_W-1-i*BYTE_W -: BYTE_W];
   end
   for (genvar j = 0; j < NUM_HLF; j++) begin : g_hlane
      assign lane_h[j] = rdata_i[DATA_W-1-j*HALF_W -: HALF_W];
   end

   always_comb begin
      sel_b = lane_b[ofs_i];
      sel_h = lane_h[ofs_i[OFS_W-1:1]];
      case (size_i)
         SZ_BYTE: data_o = {{EXT_B{~zext_i & sel_b[BYTE_W-1]}}, sel_b};
         SZ_HALF: data_o = {{EXT_H{~zext_i & sel_h[HALF_W-1]}}, sel_h};
         default: data_o = rdata_i;
      endcase
      if (misalign_i) data_o = '0;
   end

   p_zext_upper_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (zext_i && !misalign_i && size_i == SZ_BYTE) |-> (data_o[DATA_W-1:BYTE_W] == '0));
   p_sext_byte_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!zext_i && !misalign_i && size_i == SZ_BYTE && data_o[BYTE_W-1]) |-> (&data_o[DATA_W-1:BYTE_W]));
endmodule

// File: rtl/lane_store_pack.sv
module lane_store_pack
   import lane_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int BYTE_W    = 8,
   parameter int NUM_LANES = DATA_W / BYTE_W,
   parameter int OFS_W     = $clog2(NUM_LANES)
)(
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 valid_i,
   input  logic                 misalign_i,
   input  acc_size_e            size_i,
   input  logic [OFS_W-1:0]     ofs_i,
   input  logic [DATA_W-1:0]    src_i,
   output logic [DATA_W-1:0]    wdata_o,
   output logic [NUM_LANES-1:0] be_o
);
   localparam int HALF_W  = 2 * BYTE_W;
   localparam int NUM_HLF = NUM_LANES / 2;
   localparam logic [NUM_LANES-1:0] ONE_LANE = NUM_LANES'(1);
   localparam logic [NUM_LANES-1:0] TWO_LANE = NUM_LANES'(3);

   logic [DATA_W-1:0]    rep_b;
   logic [DATA_W-1:0]    rep_h;
   logic [NUM_LANES-1:0] mask;
   logic [OFS_W-2:0]     hidx;

   for (genvar i = 0; i < NUM_LANES; i++) begin : g_repb
      assign rep_b[i*BYTE_W +: BYTE_W] = src_i[BYTE_W-1:0];
   end
   for (genvar j = 0; j < NUM_HLF; j++) begin : g_reph
      assign rep_h[j*HALF_W +: HALF_W] = src_i[HALF_W-1:0];
   end

   assign hidx = ofs_i[OFS_W-1:1];

   always_comb begin
      case (size_i)
         SZ_BYTE: begin
            wdata_o = rep_b;
            mask    = ONE_LANE << (NUM_LANES - 1 - int'(ofs_i));
         end
         SZ_HALF: begin
            wdata_o = rep_h;
            mask    = TWO_LANE << (NUM_LANES - 2 - 2 * int'(hidx));
         end
         default: begin
            wdata_o = src_i;
            mask    = '1;
         end
      endcase
      be_o = (valid_i && !misalign_i) ? mask : '0;
   end

   p_byte_one_lane_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && size_i == SZ_BYTE) |-> ($countones(be_o) == 1));
   p_word_all_lanes_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && !misalign_i && (size_i == SZ_WORD || size_i == SZ_WIDE)) |-> (&be_o && wdata_o == src_i));
endmodule

// File: rtl/be_lane_unit.sv
module be_lane_unit
   import lane_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8,
   localparam int NUM_LANES = DATA_W / BYTE_W,
   localparam int OFS_W     = $clog2(NUM_LANES)
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ld_req,
   input  logic [OFS_W-1:0]     ld_ofs,
   input  logic [1:0]           ld_size,
   input  logic                 ld_zext,
   input  logic [DATA_W-1:0]    mem_rdata,
   output logic [DATA_W-1:0]    ld_data,
   output logic                 ld_misalign,
   input  logic                 st_valid,
   input  logic [OFS_W-1:0]     st_ofs,
   input  logic [1:0]           st_size,
   input  logic [DATA_W-1:0]    st_src,
   output logic [DATA_W-1:0]    mem_wdata,
   output logic [NUM_LANES-1:0] mem_be,
   output logic                 st_misalign
);
   if (BYTE_W < 1 || (DATA_W % BYTE_W) != 0 || NUM_LANES < 4 || (1 << OFS_W) != NUM_LANES) begin : g_bad_cfg
      $error("be_lane_unit: lane count must be a power of two of at least 4");
   end

   logic [OFS_W-1:0] ld_ofs_q;
   acc_size_e        ld_size_q;
   logic             ld_zext_q;
   logic             st_mis_raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ld_ofs_q  <= '0;
         ld_size_q <= SZ_WORD;
         ld_zext_q <= 1'b0;
      end else if (ld_req) begin
         ld_ofs_q  <= ld_ofs;
         ld_size_q <= acc_size_e'(ld_size);
         ld_zext_q <= ld_zext;
      end
   end

   lane_align_check #(.OFS_W(OFS_W)) u_ld_chk (
      .size_i    (ld_size_q),
      .ofs_i     (ld_ofs_q),
      .misalign_o(ld_misalign)
   );

   lane_load_extract #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_ld_ext (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .rdata_i   (mem_rdata),
      .ofs_i     (ld_ofs_q),
      .size_i    (ld_size_q),
      .zext_i    (ld_zext_q),
      .misalign_i(ld_misalign),
      .data_o    (ld_data)
   );

   lane_align_check #(.OFS_W(OFS_W)) u_st_chk (
      .size_i    (acc_size_e'(st_size)),
      .ofs_i     (st_ofs),
      .misalign_o(st_mis_raw)
   );

   assign st_misalign = st_valid & st_mis_raw;

   lane_store_pack #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_st_pack (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .valid_i   (st_valid),
      .misalign_i(st_mis_raw),
      .size_i    (acc_size_e'(st_size)),
      .ofs_i     (st_ofs),
      .src_i     (st_src),
      .wdata_o   (mem_wdata),
      .be_o      (mem_be)
   );

   p_ld_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_req |=> ($stable(ld_ofs_q) && $stable(ld_size_q) && $stable(ld_zext_q)));
   p_ld_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ld_req |=> (ld_ofs_q == $past(ld_ofs) && ld_zext_q == $past(ld_zext)));
   p_ld_mis_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ld_misalign |-> (ld_data == '0));
   p_st_mis_no_be_r11: assert property (@(posedge clk) disable iff (!rst_n)
      st_misalign |-> (mem_be == '0));
   p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !st_valid |-> (mem_be == '0 && !st_misalign));
endmodule

// File: tb/test_be_lane_unit.sv
module test_be_lane_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_req = 1'b0;
   logic [1:0]  ld_ofs = '0;
   logic [1:0]  ld_size = '0;
   logic        ld_zext = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic [31:0] ld_data;
   logic        ld_misalign;
   logic        st_valid = 1'b0;
   logic [1:0]  st_ofs = '0;
   logic [1:0]  st_size = '0;
   logic [31:0] st_src = '0;
   logic [31:0] mem_wdata;
   logic [3:0]  mem_be;
   logic        st_misalign;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   be_lane_unit i_be_lane_unit (
      .clk(clk), .rst_n(rst_n),
      .ld_req(ld_req), .ld_ofs(ld_ofs), .ld_size(ld_size), .ld_zext(ld_zext),
      .mem_rdata(mem_rdata), .ld_data(ld_data), .ld_misalign(ld_misalign),
      .st_valid(st_valid), .st_ofs(st_ofs), .st_size(st_size), .st_src(st_src),
      .mem_wdata(mem_wdata), .mem_be(mem_be), .st_misalign(st_misalign)
   );

   function automatic logic ref_mis(input logic [1:0] sz, input logic [1:0] o);
      if (sz == 2'b00) return 1'b0;
      if (sz == 2'b01) return o[0];
      return o != 2'b00;
   endfunction

   function automatic logic [31:0] ref_load(input logic [31:0] w, input logic [1:0] o,
                                            input logic [1:0] sz, input logic z);
      logic [7:0]  b;
      logic [15:0] h;
      if (ref_mis(sz, o)) return 32'h0;
      case (o)
         2'd0: b = w[31:24];
         2'd1: b = w[23:16];
         2'd2: b = w[15:8];
         default: b = w[7:0];
      endcase
      h = o[1] ? w[15:0] : w[31:16];
      if (sz == 2'b00) return (z || !b[7]) ? {24'h0, b} : {24'hFFFFFF, b};
      if (sz == 2'b01) return (z || !h[15]) ? {16'h0, h} : {16'hFFFF, h};
      return w;
   endfunction

   function automatic logic [3:0] ref_be(input logic v, input logic [1:0] sz, input logic [1:0] o);
      if (!v || ref_mis(sz, o)) return 4'b0000;
      if (sz == 2'b00) begin
         case (o)
            2'd0: return 4'b1000;
            2'd1: return 4'b0100;
            2'd2: return 4'b0010;
            default: return 4'b0001;
         endcase
      end
      if (sz == 2'b01) return o[1] ? 4'b0011 : 4'b1100;
      return 4'b1111;
   endfunction

   function automatic logic [31:0] ref_wdata(input logic [1:0] sz, input logic [31:0] s);
      if (sz == 2'b00) return {4{s[7:0]}};
      if (sz == 2'b01) return {2{s[15:0]}};
      return s;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic issue_load(input logic [1:0] o, input logic [1:0] sz, input logic z);
      @(negedge clk);
      ld_req = 1'b1; ld_ofs = o; ld_size = sz; ld_zext = z;
      @(negedge clk);
      ld_req = 1'b0; ld_ofs = ~o; ld_size = ~sz; ld_zext = ~z;
   endtask

   task automatic check_store(input string tag);
      #1;
      chk({tag, " wdata"}, mem_wdata, st_valid ? ref_wdata(st_size, st_src) : mem_wdata);
      chk({tag, " be"}, {28'h0, mem_be}, {28'h0, ref_be(st_valid, st_size, st_ofs)});
      chk({tag, " mis"}, {31'h0, st_misalign}, {31'h0, st_valid & ref_mis(st_size, st_ofs)});
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [1:0]  lo, lsz;
      logic        lz;
      int unsigned seed;
      seed = $urandom(32'd4711);
      mem_rdata = 32'hA1B2C3D4;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R1 reset state
      chk("R1 ld_data", ld_data, 32'hA1B2C3D4);
      chk("R1 ld_misalign", {31'h0, ld_misalign}, 32'h0);

      // R2/R3 byte 0xFE at offset 1, signed
      issue_load(2'd1, 2'b00, 1'b0);
      mem_rdata = 32'h12FE7F80; #1;
      chk("R2 R3 sext byte ofs1", ld_data, 32'hFFFFFFFE);
      // R6 attributes held: new rdata only
      mem_rdata = 32'h0055AA00; #1;
      chk("R6 held ofs1 rdata change", ld_data, 32'h00000055);
      // R4 zero-extend byte offset 3
      issue_load(2'd3, 2'b00, 1'b1);
      mem_rdata = 32'h12FE7F80; #1;
      chk("R4 zext byte ofs3", ld_data, 32'h00000080);
      // R5 halfword offsets
      issue_load(2'd0, 2'b01, 1'b0);
      mem_rdata = 32'h80017F02; #1;
      chk("R5 R3 half ofs0 sext", ld_data, 32'hFFFF8001);
      issue_load(2'd2, 2'b01, 1'b1);
      #1;
      chk("R5 R4 half ofs2 zext", ld_data, 32'h00007F02);
      // R7 misaligned loads
      issue_load(2'd1, 2'b01, 1'b0);
      #1;
      chk("R7 half ofs1 mis", {31'h0, ld_misalign}, 32'h1);
      chk("R7 half ofs1 data", ld_data, 32'h0);
      issue_load(2'd2, 2'b10, 1'b0);
      #1;
      chk("R7 word ofs2 mis", {31'h0, ld_misalign}, 32'h1);
      // R13 size 3 as word
      issue_load(2'd0, 2'b11, 1'b1);
      #1;
      chk("R13 load wide", ld_data, 32'h80017F02);

      // stores
      @(negedge clk);
      st_valid = 1'b1; st_src = 32'h123456AB; st_size = 2'b00; st_ofs = 2'd2; #1;
      chk("R8 byte wdata", mem_wdata, 32'hABABABAB);
      chk("R8 byte be", {28'h0, mem_be}, 32'h2);
      st_src = 32'hDEADBEEF; st_size = 2'b01; st_ofs = 2'd0; #1;
      chk("R9 half wdata", mem_wdata, 32'hBEEFBEEF);
      chk("R9 half be ofs0", {28'h0, mem_be}, 32'hC);
      st_ofs = 2'd2; #1;
      chk("R9 half be ofs2", {28'h0, mem_be}, 32'h3);
      st_size = 2'b10; st_ofs = 2'd0; #1;
      chk("R10 word wdata", mem_wdata, 32'hDEADBEEF);
      chk("R10 word be", {28'h0, mem_be}, 32'hF);
      st_ofs = 2'd3; #1;
      chk("R11 word ofs3 be", {28'h0, mem_be}, 32'h0);
      chk("R11 word ofs3 mis", {31'h0, st_misalign}, 32'h1);
      st_size = 2'b01; st_ofs = 2'd1; #1;
      chk("R11 half ofs1 be", {28'h0, mem_be}, 32'h0);
      st_size = 2'b11; st_ofs = 2'd0; #1;
      chk("R13 store wide be", {28'h0, mem_be}, 32'hF);
      st_valid = 1'b0; st_size = 2'b00; #1;
      chk("R12 idle be", {28'h0, mem_be}, 32'h0);
      chk("R12 idle mis", {31'h0, st_misalign}, 32'h0);

      // random: load data phase and store in the same cycle
      for (int it = 0; it < 400; it++) begin
         @(negedge clk);
         lo = 2'($urandom); lsz = 2'($urandom); lz = 1'($urandom);
         ld_req = 1'b1; ld_ofs = lo; ld_size = lsz; ld_zext = lz;
         st_valid = 1'($urandom); st_ofs = 2'($urandom); st_size = 2'($urandom);
         st_src = $urandom;
         check_store("R8 R9 R10 R11 R12 rnd capture");
         @(negedge clk);
         ld_req = 1'b0; ld_ofs = 2'($urandom); ld_size = 2'($urandom); ld_zext = 1'($urandom);
         mem_rdata = $urandom;
         st_valid = 1'($urandom); st_ofs = 2'($urandom); st_size = 2'($urandom);
         st_src = $urandom;
         check_store("R8 R9 R10 R11 R12 rnd overlap");
         chk("R2 R3 R4 R5 R6 R7 rnd load", ld_data, ref_load(mem_rdata, lo, lsz, lz));
         chk("R7 rnd mis", {31'h0, ld_misalign}, {31'h0, ref_mis(lsz, lo)});
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule